// File: doc/BRIEF.md
# LED Matrix Bit-Plane Scanner

This block refreshes a 32x32 RGB LED matrix that is wired as two halves of sixteen rows each. One row address selects a pair of rows, row n in the upper half and row n+16 in the lower half. Both rows of the pair take their column data at the same moment over six serial lines, one per colour per half. These lines share one shift clock, one latch strobe and one blank line. The scanner reads 12-bit pixels from two external half-panel memories, which are addressed together. Each memory holds two frame buffers. The scanner serializes one bit plane of a row pair while the previous plane is lit. It then swaps the planes under blank.

Colour depth comes from binary weighted on-times. Each row pair is shown four times in a row, once for each bit plane, starting with bit 0. Each slot is twice as long as the one before it. A brightness input dims the whole panel by ending the lit part of every slot early. The length of the slot does not change. The frame buffer used for display is switched only between frames, so a frame never shows parts of two buffers.

Top module: `bcm_led_scanner`

## Requirements
- R1: `row_sel` carries the index n of the displayed row pair. Both halves are fed from row n of their own memory. `row_sel` changes only while `blank` is high.
- R2: A pixel word holds red in [11:8], green in [7:4] and blue in [3:0]. Bit plane p drives the red, green and blue lines with bits 8+p, 4+p and p of the word.
- R3: For each row pair, planes 0, 1, 2 and 3 are shown in turn. Row pairs then go 0 to 15 and wrap to 0. A slot showing plane p lasts BASE_SLOT<<p clock cycles.
- R4: Let count k be the clock cycle within a slot. At k=0 `blank` is high. At k=1 a single-cycle latch pulse is issued with `blank` still high. At k=2 `row_sel` takes the new pair. From k=3 `blank` may go low and shifting proceeds.
- R5: The first column shifted after a latch lands in column 0, the leftmost. The 32nd column shifted lands in column 31.
- R6: The memory address is fb*512 + pair*32 + column. It is shared by both half memories. Read data is expected one clock after the address.
- R7: `blank` is low for exactly ((BASE_SLOT<<p) - 3) * dim_level / 256 cycles, rounded down, starting at k=3 of a plane-p slot. The slot length does not depend on `dim_level`.
- R8: `fb_sel` is sampled once per frame, during the slot just before pair 0 plane 0. A change in the middle of a frame leaves the remaining slots of that frame on the old buffer.
- R9: Every slot gives exactly 32 shift-clock pulses. Each pulse lasts 4 clocks, two low then two high. The data lines change only while the shift clock is low.
- R10: During reset and for one priming slot of BASE_SLOT cycles after it, `blank` stays high and no latch is issued. The priming slot shifts pair 0 plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_sel | input | 1 | Frame buffer wanted for display |
| dim_level | input | 8 | Global brightness, on fraction = dim_level/256 |
| mem_addr | output | 10 | Read address shared by both half memories |
| top_pix | input | 12 | Upper-half memory read data, one cycle after address |
| bot_pix | input | 12 | Lower-half memory read data, one cycle after address |
| shift_clk | output | 1 | Column shift clock, data sampled on its rising edge |
| latch_stb | output | 1 | Transfers shifted columns to the column outputs |
| blank | output | 1 | High turns the whole panel off |
| row_sel | output | 4 | Row pair address |
| hi_red | output | 1 | Upper-half red column data |
| hi_grn | output | 1 | Upper-half green column data |
| hi_blu | output | 1 | Upper-half blue column data |
| lo_red | output | 1 | Lower-half red column data |
| lo_grn | output | 1 | Lower-half green column data |
| lo_blu | output | 1 | Lower-half blue column data |

## Verification
Both frame buffers in the memory model are filled with seeded random pixels. Every bit differs between buffers, halves and planes, so a wrong plane, half, column order or buffer shows up as a data mismatch at the latch. The bench switches buffers in the middle of a frame and expects the old data until the frame ends, which separates a frame-boundary switch from an immediate one. Directed brightness values (full, zero, one, three quarters, half, quarter) are followed by random ones. The lit time is counted in every slot of every plane weight, so an error in rounding, offset or weighting shows up apart from the slot length.

// File: rtl/bcm_scan_pkg.sv
package bcm_scan_pkg;

    localparam int unsigned CHAN_BITS = 4;
    localparam int unsigned PIX_BITS  = 3 * CHAN_BITS;
    localparam int unsigned DIM_BITS  = 8;
    localparam int unsigned SCLK_DIV  = 4;

    // cycle indices inside one slot
    localparam int unsigned LATCH_AT  = 1;
    localparam int unsigned ROW_AT    = 2;
    localparam int unsigned ON_AT     = 3;
    localparam int unsigned FETCH_AT  = 2;
    localparam int unsigned SHIFT_AT  = 4;

    typedef struct packed {
        logic red;
        logic grn;
        logic blu;
    } rgb_bit_t;

    function automatic rgb_bit_t plane_bits(
        input logic [PIX_BITS-1:0]          pix,
        input logic [$clog2(CHAN_BITS)-1:0] plane
    );
        rgb_bit_t b;
        b.red = pix[2*CHAN_BITS + int'(plane)];
        b.grn = pix[CHAN_BITS + int'(plane)];
        b.blu = pix[int'(plane)];
        return b;
    endfunction

endpackage

// File: rtl/bcm_slot_seq.sv
module bcm_slot_seq
    import bcm_scan_pkg::*;
#(
    parameter int unsigned PAIRS     = 16,
    parameter int unsigned BASE_SLOT = 2080,
    parameter int unsigned PLW       = 2,
    parameter int unsigned PRW       = 4,
    parameter int unsigned CW        = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fb_sel,
    output logic [CW-1:0]  n_cnt,
    output logic [PLW-1:0] n_plane,
    output logic [PRW-1:0] n_pair,
    output logic           n_prime,
    output logic           n_fb,
    output logic [PLW-1:0] t_plane,
    output logic [PRW-1:0] t_pair,
    output logic           prime_o
);
    localparam int unsigned PLANES = CHAN_BITS;

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [PLW-1:0] plane;
        logic [PRW-1:0] pair;
        logic           prime;
        logic           fb;
    } seq_t;

    seq_t s_d, s_q;
    logic [CW-1:0]  len_q;
    logic [PLW-1:0] tpl_d, tpl_q;
    logic [PRW-1:0] tpr_d, tpr_q;

    // slot whose plane is shifted while slot s is displayed
    function automatic logic [PRW+PLW-1:0] target_of(input seq_t s);
        logic [PRW-1:0] p;
        logic [PLW-1:0] b;
        if (s.prime) begin
            p = '0;
            b = '0;
        end else if (s.plane == PLW'(PLANES - 1)) begin
            b = '0;
            p = (s.pair == PRW'(PAIRS - 1)) ? '0 : s.pair + 1'b1;
        end else begin
            b = s.plane + 1'b1;
            p = s.pair;
        end
        return {p, b};
    endfunction

    always_comb begin
        len_q = s_q.prime ? CW'(BASE_SLOT) : (CW'(BASE_SLOT) << s_q.plane);
        {tpr_q, tpl_q} = target_of(s_q);
        s_d = s_q;
        if (s_q.cnt == len_q - 1'b1) begin
            s_d.cnt   = '0;
            s_d.pair  = tpr_q;
            s_d.plane = tpl_q;
            s_d.prime = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        {tpr_d, tpl_d} = target_of(s_d);
        if (s_d.cnt == CW'(LATCH_AT) && tpr_d == '0 && tpl_d == '0)
            s_d.fb = fb_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.plane <= PLW'(PLANES - 1);
            s_q.pair  <= PRW'(PAIRS - 1);
            s_q.prime <= 1'b1;
            s_q.fb    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign n_cnt   = s_d.cnt;
    assign n_plane = s_d.plane;
    assign n_pair  = s_d.pair;
    assign n_prime = s_d.prime;
    assign n_fb    = s_d.fb;
    assign t_plane = tpl_d;
    assign t_pair  = tpr_d;
    assign prime_o = s_q.prime;

    // R8
    fb_frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.fb) |-> (s_q.cnt == CW'(LATCH_AT) && tpr_q == '0 && tpl_q == '0));

    // R3
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < len_q);

endmodule

// File: rtl/bcm_col_shift.sv
module bcm_col_shift
    import bcm_scan_pkg::*;
#(
    parameter int unsigned COLS = 32,
    parameter int unsigned PLW  = 2,
    parameter int unsigned PRW  = 4,
    parameter int unsigned CW   = 15,
    parameter int unsigned AW   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       n_cnt,
    input  logic [PLW-1:0]      t_plane,
    input  logic [PRW-1:0]      t_pair,
    input  logic                n_fb,
    input  logic [PIX_BITS-1:0] top_pix,
    input  logic [PIX_BITS-1:0] bot_pix,
    output logic [AW-1:0]       mem_addr,
    output logic                shift_clk,
    output logic [2:0]          hi_bits,
    output logic [2:0]          lo_bits
);
    localparam int unsigned COLW = $clog2(COLS);
    localparam int unsigned SDW  = $clog2(SCLK_DIV);
    localparam int unsigned SPAN = SCLK_DIV * COLS;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          sclk;
        rgb_bit_t      hi;
        rgb_bit_t      lo;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [CW-1:0] f_off, s_off;
    logic          f_win, s_win;

    always_comb begin
        sh_d  = sh_q;
        f_off = n_cnt - CW'(FETCH_AT);
        s_off = n_cnt - CW'(SHIFT_AT);
        f_win = (n_cnt >= CW'(FETCH_AT)) && (n_cnt < CW'(FETCH_AT + SPAN));
        s_win = (n_cnt >= CW'(SHIFT_AT)) && (n_cnt < CW'(SHIFT_AT + SPAN));
        if (f_win && f_off[SDW-1:0] == '0)
            sh_d.addr = {n_fb, t_pair, f_off[SDW +: COLW]};
        if (s_win && s_off[SDW-1:0] == '0) begin
            sh_d.hi = plane_bits(top_pix, t_plane);
            sh_d.lo = plane_bits(bot_pix, t_plane);
        end
        sh_d.sclk = s_win && (s_off[SDW-1:0] >= SDW'(SCLK_DIV / 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign mem_addr  = sh_q.addr;
    assign shift_clk = sh_q.sclk;
    assign hi_bits   = sh_q.hi;
    assign lo_bits   = sh_q.lo;

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.sclk |-> $stable({sh_q.hi, sh_q.lo}));

    // R9
    sclk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.sclk) |=> sh_q.sclk);

endmodule

// File: rtl/bcm_blank_ctl.sv
module bcm_blank_ctl
    import bcm_scan_pkg::*;
#(
    parameter int unsigned BASE_SLOT = 2080,
    parameter int unsigned PLW       = 2,
    parameter int unsigned PRW       = 4,
    parameter int unsigned CW        = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       n_cnt,
    input  logic [PLW-1:0]      n_plane,
    input  logic [PRW-1:0]      n_pair,
    input  logic                n_prime,
    input  logic [DIM_BITS-1:0] dim_level,
    output logic                blank,
    output logic                latch_stb,
    output logic [PRW-1:0]      row_sel
);
    localparam int unsigned PW = CW + DIM_BITS;

    typedef struct packed {
        logic           blank;
        logic           latch;
        logic [PRW-1:0] row;
    } bc_t;

    bc_t bc_d, bc_q;
    logic [CW-1:0] len_n, on_len, rel;
    logic [PW-1:0] prod;
    logic          lit;

    always_comb begin
        bc_d   = bc_q;
        len_n  = CW'(BASE_SLOT) << n_plane;
        prod   = PW'(len_n - CW'(ON_AT)) * PW'(dim_level);
        on_len = prod[DIM_BITS +: CW];
        rel    = n_cnt - CW'(ON_AT);
        lit    = !n_prime && (n_cnt >= CW'(ON_AT)) && (rel < on_len);
        bc_d.blank = !lit;
        bc_d.latch = !n_prime && (n_cnt == CW'(LATCH_AT));
        if (!n_prime && n_cnt == CW'(ROW_AT))
            bc_d.row = n_pair;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q.blank <= 1'b1;
            bc_q.latch <= 1'b0;
            bc_q.row   <= '0;
        end else begin
            bc_q <= bc_d;
        end
    end

    assign blank     = bc_q.blank;
    assign latch_stb = bc_q.latch;
    assign row_sel   = bc_q.row;

    // R4
    latch_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_q.latch |-> bc_q.blank);

    // R4
    latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_q.latch |=> !bc_q.latch);

    // R1
    row_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bc_q.row) |-> bc_q.blank);

endmodule

// File: rtl/bcm_led_scanner.sv
module bcm_led_scanner
    import bcm_scan_pkg::*;
#(
    parameter int unsigned COLS      = 32,
    parameter int unsigned PAIRS     = 16,
    parameter int unsigned BASE_SLOT = 2080
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   fb_sel,
    input  logic [DIM_BITS-1:0]                    dim_level,
    output logic [$clog2(PAIRS)+$clog2(COLS):0]    mem_addr,
    input  logic [PIX_BITS-1:0]                    top_pix,
    input  logic [PIX_BITS-1:0]                    bot_pix,
    output logic                                   shift_clk,
    output logic                                   latch_stb,
    output logic                                   blank,
    output logic [$clog2(PAIRS)-1:0]               row_sel,
    output logic                                   hi_red,
    output logic                                   hi_grn,
    output logic                                   hi_blu,
    output logic                                   lo_red,
    output logic                                   lo_grn,
    output logic                                   lo_blu
);
    localparam int unsigned PLANES = CHAN_BITS;
    localparam int unsigned PLW    = $clog2(PLANES);
    localparam int unsigned PRW    = $clog2(PAIRS);
    localparam int unsigned COLW   = $clog2(COLS);
    localparam int unsigned CW     = $clog2(BASE_SLOT << (PLANES - 1)) + 1;
    localparam int unsigned AW     = 1 + PRW + COLW;

    logic [CW-1:0]  n_cnt;
    logic [PLW-1:0] n_plane, t_plane;
    logic [PRW-1:0] n_pair, t_pair;
    logic           n_prime, n_fb, prime_q;
    logic [2:0]     hi_bits, lo_bits;

    bcm_slot_seq #(
        .PAIRS(PAIRS), .BASE_SLOT(BASE_SLOT), .PLW(PLW), .PRW(PRW), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .fb_sel(fb_sel),
        .n_cnt(n_cnt), .n_plane(n_plane), .n_pair(n_pair), .n_prime(n_prime),
        .n_fb(n_fb), .t_plane(t_plane), .t_pair(t_pair), .prime_o(prime_q)
    );

    bcm_col_shift #(
        .COLS(COLS), .PLW(PLW), .PRW(PRW), .CW(CW), .AW(AW)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .n_cnt(n_cnt), .t_plane(t_plane),
        .t_pair(t_pair), .n_fb(n_fb), .top_pix(top_pix), .bot_pix(bot_pix),
        .mem_addr(mem_addr), .shift_clk(shift_clk),
        .hi_bits(hi_bits), .lo_bits(lo_bits)
    );

    bcm_blank_ctl #(
        .BASE_SLOT(BASE_SLOT), .PLW(PLW), .PRW(PRW), .CW(CW)
    ) u_blank (
        .clk(clk), .rst_n(rst_n), .n_cnt(n_cnt), .n_plane(n_plane),
        .n_pair(n_pair), .n_prime(n_prime), .dim_level(dim_level),
        .blank(blank), .latch_stb(latch_stb), .row_sel(row_sel)
    );

    assign {hi_red, hi_grn, hi_blu} = hi_bits;
    assign {lo_red, lo_grn, lo_blu} = lo_bits;

    // R10
    prime_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prime_q |-> (blank && !latch_stb));

endmodule

// File: tb/sim_bcm_led_scanner.sv
module sim_bcm_led_scanner;
    localparam int BASE  = 160;
    localparam int TOTAL = 194;

    logic clk = 1'b0;
    logic rst_n;
    logic fb_sel;
    logic [7:0] dim_level;
    logic [9:0] mem_addr;
    logic [11:0] top_pix, bot_pix;
    logic shift_clk, latch_stb, blank;
    logic [3:0] row_sel;
    logic hi_red, hi_grn, hi_blu, lo_red, lo_grn, lo_blu;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    bcm_led_scanner #(.COLS(32), .PAIRS(16), .BASE_SLOT(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .fb_sel(fb_sel), .dim_level(dim_level),
        .mem_addr(mem_addr), .top_pix(top_pix), .bot_pix(bot_pix),
        .shift_clk(shift_clk), .latch_stb(latch_stb), .blank(blank),
        .row_sel(row_sel), .hi_red(hi_red), .hi_grn(hi_grn), .hi_blu(hi_blu),
        .lo_red(lo_red), .lo_grn(lo_grn), .lo_blu(lo_blu)
    );

    // half-panel memories, one-cycle read
    logic [11:0] mem_t [1024];
    logic [11:0] mem_b [1024];
    always @(posedge clk) begin
        top_pix <= mem_t[mem_addr];
        bot_pix <= mem_b[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int on_len(input int plane, input int br);
        return (((BASE << plane) - 3) * br) >> 8;
    endfunction

    // ch: 0 red, 1 green, 2 blue
    function automatic logic exp_bit(input bit bottom, input int fb, input int pair,
                                     input int col, input int plane, input int ch);
        logic [11:0] w;
        int a;
        a = fb * 512 + pair * 32 + col;
        w = bottom ? mem_b[a] : mem_t[a];
        case (ch)
            0:       return w[8 + plane];
            1:       return w[4 + plane];
            default: return w[plane];
        endcase
    endfunction

    // monitor
    logic [31:0] cap [6];
    int  col_idx = 0, sclk_cnt = 0, low_cnt = 0, since = 0, nlatch = 0;
    int  e_pair = 0, e_plane = 0, cur_pair = 0, prev_plane = 0, br_rec = 0;
    int  frame_fb = 0;
    logic prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (shift_clk && !prev_sclk) begin
                if (col_idx < 32) begin
                    cap[0][col_idx] = hi_red; cap[1][col_idx] = hi_grn;
                    cap[2][col_idx] = hi_blu; cap[3][col_idx] = lo_red;
                    cap[4][col_idx] = lo_grn; cap[5][col_idx] = lo_blu;
                end
                col_idx++;
                sclk_cnt++;
            end
            prev_sclk = shift_clk;
            if (!blank) low_cnt++;
            since++;
            if (nlatch > 0 && since == 1)
                check(row_sel == 4'(cur_pair), "R1 row pair after latch", row_sel, cur_pair);
            if (since == 2) br_rec = dim_level;
            if (latch_stb) begin
                check(blank == 1'b1, "R4 blank during latch", blank, 1);
                check(row_sel == 4'(cur_pair), "R4 row held at latch", row_sel, cur_pair);
                check(sclk_cnt == 32, "R9 pulses per slot", sclk_cnt, 32);
                if (nlatch == 0) begin
                    check(low_cnt == 0, "R10 dark priming slot", low_cnt, 0);
                end else begin
                    check(since == (BASE << prev_plane), "R3 slot length", since, BASE << prev_plane);
                    check(low_cnt == on_len(prev_plane, br_rec), "R7 lit cycles",
                          low_cnt, on_len(prev_plane, br_rec));
                end
                if (e_pair == 0 && e_plane == 0) frame_fb = int'(fb_sel);
                for (int ln = 0; ln < 6; ln++) begin
                    logic [31:0] ex;
                    for (int c = 0; c < 32; c++)
                        ex[c] = exp_bit(ln >= 3, frame_fb, e_pair, c, e_plane, ln % 3);
                    check(cap[ln] == ex, "R2/R5/R6/R8 column data", int'(cap[ln]), int'(ex));
                end
                cur_pair   = e_pair;
                prev_plane = e_plane;
                if (e_plane == 3) begin
                    e_plane = 0;
                    e_pair  = (e_pair + 1) % 16;
                end else begin
                    e_plane++;
                end
                nlatch++;
                since = 0; low_cnt = 0; sclk_cnt = 0; col_idx = 0;
            end
        end
    end

    // stimulus
    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            mem_t[i] = 12'($urandom);
            mem_b[i] = 12'($urandom);
        end
        rst_n = 1'b0; fb_sel = 1'b0; dim_level = 8'd255;
        repeat (4) @(negedge clk);
        check(blank == 1'b1, "R10 reset blank", blank, 1);
        check(latch_stb == 1'b0, "R10 reset latch", latch_stb, 0);
        check(shift_clk == 1'b0, "R10 reset shift clock", shift_clk, 0);
        rst_n = 1'b1;
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk iff latch_stb);
            case (k)
                0: dim_level = 8'd255;
                1: dim_level = 8'd0;
                2: dim_level = 8'd192;
                3: dim_level = 8'd1;
                4: dim_level = 8'd128;
                5: dim_level = 8'd64;
                default: dim_level = 8'($urandom_range(0, 255));
            endcase
            if (k == 20)  fb_sel = 1'b1;
            if (k == 148) fb_sel = 1'b0;
        end
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", nlatch, TOTAL);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule